// File: doc/BRIEF.md
# Inter-processor interrupt mailbox controller

This block lets a small group of processor agents (four by default) interrupt one another and pass short messages. Every agent has its own register set, reached through one shared word-addressed register bus. Through that set an agent can raise an interrupt at any other agent, see which of its own raised interrupts are still waiting to be serviced, and see which agents have raised one at it. It can also mask, unmask and acknowledge those incoming interrupts.

The acknowledge path is built into the hardware. When the destination clears a pending bit in its status register, the matching bit in the source's observation register falls in the same cycle. Each ordered pair of agents also owns two small buffers of 8 words: a message buffer that the source fills, and a response buffer that the destination fills. Each agent has one interrupt output. It is high while any unmasked status bit of that agent is set.

The bus uses a word address with the default width of 9 bits. Bit 8 selects the region: 0 selects the registers and 1 selects the buffers. In the register region, bits [2:0] select the register: 0 trigger, 1 observation, 2 status, 3 mask, 4 enable, 5 disable. Bits [4:3] give the agent, and bits [7:5] must be zero. In the buffer region, bits [2:0] give the word and bit 3 gives the type (0 message, 1 response). Bits [5:4] give the destination and bits [7:6] give the source. Read data is combinational from the address while `bus_en` is high and `bus_we` is low. A write takes effect at the clock edge on which `bus_en` and `bus_we` are both high.

Top module: `ipi_mailbox`

## Requirements
- R1: A write of data d to the trigger register (selector 0) of agent i sets status bit i of agent j and observation bit j of agent i, for every j where d[j] is 1, from the next cycle on. Zero bits change nothing.
- R2: The status register (selector 2) is write-one-to-clear. Writing a 1 to bit s of agent a's status clears that bit and also clears observation bit a of agent s in the same cycle. Zero bits change nothing.
- R3: The mask register (selector 3) reads back one bit per source, where 1 means masked. Writing 1s to the enable register (selector 4) clears those mask bits. Writing 1s to the disable register (selector 5) sets them. Zero bits change neither.
- R4: In any write to the trigger, status, enable or disable registers, data bits at positions N_AGENTS and above are ignored.
- R5: The output irq[j] equals the OR of agent j's status bits whose mask bit is 0. It follows a change of status or mask one clock cycle after that register changes.
- R6: After reset every mask bit is 1, and all status bits, observation bits, buffer words and irq outputs are 0.
- R7: Every source/destination pair has 8 message words and 8 response words, each 32 bits wide. Each word is stored independently and read back unchanged at its own address.
- R8: The following reads return 0: the trigger, enable and disable registers, selectors 6 and 7, and register addresses whose bits [7:5] are not zero. Writes to selectors 6 and 7, or to addresses with nonzero bits [7:5], change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (9 bits by default) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| irq | output | N_AGENTS | One interrupt line per agent |

## Verification
The trigger, acknowledge and mask paths are exercised in two ways: with directed single-bit patterns and with random multi-bit patterns that include set bits above the agent count.

- A single trigger followed by a read shows whether the status bit and the observation bit land in the transposed positions, rather than both in the writer's own set.
- A clear with the wrong bit set, and then with the right bit set, separates write-one-to-clear behaviour from plain overwrite, and proves that the source's observation bit falls with it.
- Sampling irq both one cycle and two cycles after a trigger pins the one-cycle latency.
- Random mixes of enable, disable, trigger, clear and buffer writes, some at unimplemented selectors or padded addresses, are compared against a bench model of all state.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        SEL_TRIG = 3'd0,
        SEL_OBS  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_MASK = 3'd3,
        SEL_EN   = 3'd4,
        SEL_DIS  = 3'd5
    } reg_sel_e;

    localparam int unsigned SEL_LAST = 5;

endpackage

// File: rtl/ipi_signal_core.sv
module ipi_signal_core
    import ipi_pkg::*;
#(
    parameter int unsigned N_AGENTS = 4,
    localparam int unsigned AW = $clog2(N_AGENTS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_valid,
    input  logic [AW-1:0]                      wr_agent,
    input  reg_sel_e                           wr_sel,
    input  logic [N_AGENTS-1:0]                wr_bits,
    output logic [N_AGENTS-1:0][N_AGENTS-1:0]  status_o,
    output logic [N_AGENTS-1:0][N_AGENTS-1:0]  obs_o,
    output logic [N_AGENTS-1:0][N_AGENTS-1:0]  mask_o,
    output logic [N_AGENTS-1:0]                irq_o
);

    // status[dst][src], obs[src][dst], mask[dst][src]
    typedef struct packed {
        logic [N_AGENTS-1:0][N_AGENTS-1:0] status;
        logic [N_AGENTS-1:0][N_AGENTS-1:0] obs;
        logic [N_AGENTS-1:0][N_AGENTS-1:0] mask;
        logic [N_AGENTS-1:0]               irq;
    } sig_state_t;

    sig_state_t sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (wr_valid) begin
            case (wr_sel)
                SEL_TRIG: begin
                    for (int j = 0; j < N_AGENTS; j++) begin
                        if (wr_bits[j]) begin
                            sig_d.status[j][wr_agent] = 1'b1;
                            sig_d.obs[wr_agent][j]    = 1'b1;
                        end
                    end
                end
                SEL_STAT: begin
                    for (int s = 0; s < N_AGENTS; s++) begin
                        if (wr_bits[s]) begin
                            sig_d.status[wr_agent][s] = 1'b0;
                            sig_d.obs[s][wr_agent]    = 1'b0;
                        end
                    end
                end
                SEL_EN:  sig_d.mask[wr_agent] = sig_q.mask[wr_agent] & ~wr_bits;
                SEL_DIS: sig_d.mask[wr_agent] = sig_q.mask[wr_agent] | wr_bits;
                default: ;
            endcase
        end
        for (int j = 0; j < N_AGENTS; j++) begin
            sig_d.irq[j] = |(sig_q.status[j] & ~sig_q.mask[j]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q.status <= '0;
            sig_q.obs    <= '0;
            sig_q.mask   <= '1;
            sig_q.irq    <= '0;
        end else begin
            sig_q <= sig_d;
        end
    end

    assign status_o = sig_q.status;
    assign obs_o    = sig_q.obs;
    assign mask_o   = sig_q.mask;
    assign irq_o    = sig_q.irq;

    for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_row
        // R5: an asserted line must come from an unmasked pending bit one cycle earlier
        assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sig_q.irq[gi] |-> ($past(sig_q.status[gi] & ~sig_q.mask[gi]) != '0));

        for (genvar gj = 0; gj < N_AGENTS; gj++) begin : g_col
            assert_obs_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
                sig_q.obs[gi][gj] == sig_q.status[gj][gi]);

            assert_trig_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_sel == SEL_TRIG && wr_agent == AW'(gi) && wr_bits[gj])
                |=> (sig_q.status[gj][gi] && sig_q.obs[gi][gj]));

            assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_sel == SEL_STAT && wr_agent == AW'(gi) && wr_bits[gj])
                |=> (!sig_q.status[gi][gj] && !sig_q.obs[gj][gi]));

            assert_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_sel == SEL_DIS && wr_agent == AW'(gi) && wr_bits[gj])
                |=> sig_q.mask[gi][gj]);

            assert_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_sel == SEL_EN && wr_agent == AW'(gi) && wr_bits[gj])
                |=> !sig_q.mask[gi][gj]);

            assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_valid && (wr_sel == SEL_EN || wr_sel == SEL_DIS)
                  && wr_agent == AW'(gi) && wr_bits[gj])
                |=> $stable(sig_q.mask[gi][gj]));
        end
    end

endmodule

// File: rtl/ipi_msg_store.sv
module ipi_msg_store #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[rd_idx];

    assert_store_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int unsigned N_AGENTS  = 4,
    parameter int unsigned BUF_WORDS = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned AW     = $clog2(N_AGENTS),
    localparam int unsigned WW     = $clog2(BUF_WORDS),
    localparam int unsigned ADDR_W = 2 * AW + WW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_AGENTS-1:0] irq
);

    localparam int unsigned DEPTH = 1 << (ADDR_W - 1);
    localparam int unsigned IW    = ADDR_W - 1;
    localparam int unsigned PAD_W = ADDR_W - 1 - (AW + 3);

    logic                               is_buf;
    logic [2:0]                         r_sel;
    logic [AW-1:0]                      r_agent;
    logic [PAD_W-1:0]                   r_pad;
    logic                               reg_hit;
    logic [AW-1:0]                      b_src, b_dst;
    logic                               buf_hit;
    logic [IW-1:0]                      b_idx;
    logic [N_AGENTS-1:0]                wr_bits;
    logic [N_AGENTS-1:0][N_AGENTS-1:0]  status_w, obs_w, mask_w;
    logic [DATA_W-1:0]                  buf_rdata;
    logic                               rd_act;

    // address decode
    always_comb begin
        is_buf  = bus_addr[ADDR_W-1];
        r_sel   = bus_addr[2:0];
        r_agent = bus_addr[AW+2:3];
        r_pad   = bus_addr[ADDR_W-2:AW+3];
        reg_hit = !is_buf && (r_pad == '0) && (int'(r_agent) < N_AGENTS)
                  && (int'(r_sel) <= SEL_LAST);
        b_dst   = bus_addr[WW+AW:WW+1];
        b_src   = bus_addr[WW+2*AW:WW+AW+1];
        b_idx   = bus_addr[IW-1:0];
        buf_hit = is_buf && (int'(b_src) < N_AGENTS) && (int'(b_dst) < N_AGENTS);
        wr_bits = bus_wdata[N_AGENTS-1:0];  // drops bits beyond the agent count
    end

    ipi_signal_core #(.N_AGENTS(N_AGENTS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (bus_en && bus_we && reg_hit),
        .wr_agent (r_agent),
        .wr_sel   (reg_sel_e'(r_sel)),
        .wr_bits  (wr_bits),
        .status_o (status_w),
        .obs_o    (obs_w),
        .mask_o   (mask_w),
        .irq_o    (irq)
    );

    ipi_msg_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_en && bus_we && buf_hit),
        .wr_idx  (b_idx),
        .wr_data (bus_wdata),
        .rd_idx  (b_idx),
        .rd_data (buf_rdata)
    );

    // read mux
    always_comb begin
        rd_act    = bus_en && !bus_we;
        bus_rdata = '0;
        if (rd_act && buf_hit) begin
            bus_rdata = buf_rdata;
        end else if (rd_act && reg_hit) begin
            case (reg_sel_e'(r_sel))
                SEL_OBS:  bus_rdata[N_AGENTS-1:0] = obs_w[r_agent];
                SEL_STAT: bus_rdata[N_AGENTS-1:0] = status_w[r_agent];
                SEL_MASK: bus_rdata[N_AGENTS-1:0] = mask_w[r_agent];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_unimpl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !is_buf && !reg_hit) |-> (bus_rdata == '0));

    assert_reset_mask_R6: assert property (@(posedge clk)
        !rst_n |=> (mask_w == '1 && status_w == '0));

endmodule

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  stat_m [4];
    logic [3:0]  mask_m [4];
    logic [31:0] buf_m  [256];

    always #5 clk = ~clk;

    ipi_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [8:0] reg_addr(int agent, int sel);
        return {1'b0, 3'b000, 2'(agent), 3'(sel)};
    endfunction

    function automatic logic [8:0] buf_addr(int src, int dst, int typ, int word);
        return {1'b1, 2'(src), 2'(dst), 1'(typ), 3'(word)};
    endfunction

    function automatic logic [3:0] exp_obs(int a);
        logic [3:0] v;
        for (int j = 0; j < 4; j++) v[j] = stat_m[j][a];
        return v;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int j = 0; j < 4; j++) v[j] = |(stat_m[j] & ~mask_m[j]);
        return v;
    endfunction

    task automatic model_write(logic [8:0] a, logic [31:0] d);
        int ag;
        logic [3:0] b;
        if (a[8]) begin
            buf_m[a[7:0]] = d;
        end else if (a[7:5] == 3'b000) begin
            ag = int'(a[4:3]);
            b  = d[3:0];
            case (a[2:0])
                3'd0: for (int j = 0; j < 4; j++) if (b[j]) stat_m[j][ag] = 1'b1;
                3'd2: stat_m[ag] = stat_m[ag] & ~b;
                3'd4: mask_m[ag] = mask_m[ag] & ~b;
                3'd5: mask_m[ag] = mask_m[ag] | b;
                default: ;
            endcase
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(logic [8:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
        bus_en = 1'b0;
    endtask

    task automatic check_agent(int a, string tag);
        rd_chk(reg_addr(a, 1), {28'b0, exp_obs(a)}, {tag, " obs R1"});
        rd_chk(reg_addr(a, 2), {28'b0, stat_m[a]}, {tag, " status R2"});
        rd_chk(reg_addr(a, 3), {28'b0, mask_m[a]}, {tag, " mask R3"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h0005EED5);
        for (int i = 0; i < 4; i++) begin stat_m[i] = '0; mask_m[i] = 4'hF; end
        for (int i = 0; i < 256; i++) buf_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        for (int a = 0; a < 4; a++) check_agent(a, "R6 reset");
        chk("R6 reset irq", {28'b0, irq}, 32'h0);
        rd_chk(buf_addr(2, 1, 1, 5), 32'h0, "R6 reset buffer");

        // R5 latency: unmask agent 1, agent 0 triggers agent 1
        bus_write(reg_addr(1, 4), 32'h0000_000F);
        bus_write(reg_addr(0, 0), 32'h0000_0002);
        chk("R5 irq not yet at first cycle", {28'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R5 irq after one cycle", {28'b0, irq}, 32'h2);
        check_agent(0, "R1 trigger src");
        check_agent(1, "R1 trigger dst");

        // R2: wrong bit clears nothing, right bit clears and acks
        bus_write(reg_addr(1, 2), 32'h0000_0002);
        rd_chk(reg_addr(1, 2), 32'h1, "R2 zero bits keep status");
        bus_write(reg_addr(1, 2), 32'h0000_0001);
        rd_chk(reg_addr(1, 2), 32'h0, "R2 status cleared");
        rd_chk(reg_addr(0, 1), 32'h0, "R2 observation acked");
        chk("R5 irq falls", {28'b0, irq}, 32'h0);

        // R4: high bits ignored
        bus_write(reg_addr(2, 0), 32'hFFFF_FFF0);
        bus_write(reg_addr(3, 5), 32'hFFFF_FFF0);
        for (int a = 0; a < 4; a++) check_agent(a, "R4 high bits");

        // R8: unimplemented selectors, padded addresses, write-only readback
        bus_write(reg_addr(0, 6), 32'hFFFF_FFFF);
        bus_write(reg_addr(0, 7), 32'hFFFF_FFFF);
        bus_write(9'b0_101_00_000, 32'hFFFF_FFFF);
        bus_write(9'b0_001_10_100, 32'hFFFF_FFFF);
        for (int a = 0; a < 4; a++) check_agent(a, "R8 no effect");
        rd_chk(reg_addr(1, 6), 32'h0, "R8 selector 6 reads zero");
        rd_chk(reg_addr(1, 0), 32'h0, "R8 trigger reads zero");
        rd_chk(reg_addr(1, 4), 32'h0, "R8 enable reads zero");
        rd_chk(reg_addr(1, 5), 32'h0, "R8 disable reads zero");
        rd_chk({1'b0, 3'b010, 2'd1, 3'd3}, 32'h0, "R8 padded read zero");

        // R7: message and response kept apart per path
        bus_write(buf_addr(0, 3, 0, 7), 32'hA5A5_0001);
        bus_write(buf_addr(0, 3, 1, 7), 32'h5A5A_0002);
        bus_write(buf_addr(3, 0, 0, 7), 32'h1234_5678);
        rd_chk(buf_addr(0, 3, 0, 7), 32'hA5A5_0001, "R7 message word");
        rd_chk(buf_addr(0, 3, 1, 7), 32'h5A5A_0002, "R7 response word");
        rd_chk(buf_addr(3, 0, 0, 7), 32'h1234_5678, "R7 reverse path");
        rd_chk(buf_addr(0, 3, 0, 6), 32'h0, "R7 neighbour word untouched");

        // random mix checked against the model
        for (int it = 0; it < 600; it++) begin
            int op;
            int ag;
            logic [8:0] a;
            logic [31:0] d;
            op = int'($urandom_range(0, 9));
            ag = int'($urandom_range(0, 3));
            d  = $urandom();
            if (op < 3)       a = reg_addr(ag, 0);
            else if (op < 5)  a = reg_addr(ag, 2);
            else if (op == 5) a = reg_addr(ag, 4);
            else if (op == 6) a = reg_addr(ag, 5);
            else if (op == 7) a = {1'b0, 3'($urandom()), 2'(ag), 3'($urandom())};
            else              a = {1'b1, 8'($urandom())};
            bus_write(a, d);
            @(negedge clk);
            chk("R5 random irq", {28'b0, irq}, {28'b0, exp_irq()});
            check_agent(int'($urandom_range(0, 3)), "R1 R2 R3 random");
            begin
                logic [8:0] ba;
                ba = {1'b1, 8'($urandom())};
                rd_chk(ba, buf_m[ba[7:0]], "R7 random buffer");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule